// File: doc/BRIEF.md
# Two-Cycle Command Register Controller

This block decodes the write cycles that an external host issues to a bulk-erasable, byte-reprogrammable memory. It works on the device side, in the core clock domain. It samples the active-low chip-enable and write-enable strobes together with the address and data buses. It takes the address when write-enable falls and the data byte when write-enable rises. Each completed write goes to a mode state machine. That machine selects read, erase setup, erasing, erase verify, program setup, programming or program verify.

The controller issues one-cycle start pulses to the program and erase engines. It issues a one-cycle stop pulse when a running program or erase is ended. It presents the operation address and program byte to the array datapath. A select output steers the read path to verify data instead of plain array data. Writes have an effect only while the high programming supply is reported present and the internal write lockout is released. When the supply is absent the machine is held in read mode.

Top module: `cmdreg_ctrl`

## Requirements
- R1: After reset the mode output is read (code 0), the verify select, the busy outputs and all pulses are low.
- R2: A write is accepted only when chip-enable is low at both write-enable edges. The address is the value present when write-enable falls, and the data is the value present when it rises.
- R3: Byte 00h selects read mode (code 0) from any non-running mode.
- R4: Byte 20h selects erase setup (code 1). A second 20h written directly after it gives one erase_start pulse and erasing mode (code 2) with erase_busy high.
- R5: In erase setup, any byte other than 20h returns to read mode (code 0) and starts no erase.
- R6: Byte A0h selects erase verify (code 3). op_addr takes that write's address and verify_sel goes high.
- R7: Byte 40h selects program setup (code 4). The next write gives one prog_start pulse, programming mode (code 5), and op_addr/prog_data equal to that write's address and byte.
- R8: Byte C0h selects program verify (code 6) and keeps op_addr from the program write. Any accepted write while programming or erasing ends the operation with one op_stop pulse.
- R9: In program setup, FFh is taken as program data (prog_start with byte FFh). A second FFh then gives op_stop and read mode.
- R10: Two consecutive FFh writes return to read mode from any mode. A lone FFh in a verify mode leaves the mode unchanged.
- R11: While hv_ok is low, writes are ignored and the mode is forced to read. A running operation ends with op_stop.
- R12: While lockout is high, writes are ignored and the mode does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low, synchronous to clk |
| we_n | input | 1 | Write enable strobe, active low |
| addr | input | AW | Host address bus |
| din | input | DW | Host data bus |
| hv_ok | input | 1 | High programming supply present |
| lockout | input | 1 | Internal not-ready / under-voltage write lockout |
| mode | output | 3 | Current mode code |
| verify_sel | output | 1 | Read path selects verify data |
| prog_start | output | 1 | One-cycle program start |
| erase_start | output | 1 | One-cycle bulk erase start |
| op_stop | output | 1 | One-cycle end of running program or erase |
| prog_busy | output | 1 | Programming in progress |
| erase_busy | output | 1 | Erase in progress |
| op_addr | output | AW | Address for program or erase verify |
| prog_data | output | DW | Byte to be programmed |

## Verification
The hardest situation to reach is the ambiguous FFh that follows program setup. It must program null data and arm the abort, and only a second FFh may end the program. The stimulus writes 40h, then FFh, then FFh. It expects a prog_start pulse carrying FFh and then an op_stop. A lone FFh in erase verify and a non-20h byte in erase setup are written to show the contrast. The address and data capture points are reached by changing the address bus and the data bus while write-enable is low. The scoreboard then confirms which values the program pulse carried.

// File: rtl/cmdreg_pkg.sv
package cmdreg_pkg;
  typedef enum logic [2:0] {
    M_READ     = 3'd0,
    M_ERS_SET  = 3'd1,
    M_ERASING  = 3'd2,
    M_ERS_VFY  = 3'd3,
    M_PRG_SET  = 3'd4,
    M_PROGRAM  = 3'd5,
    M_PRG_VFY  = 3'd6
  } mode_e;

  localparam logic [7:0] CMD_READ     = 8'h00;
  localparam logic [7:0] CMD_ERASE    = 8'h20;
  localparam logic [7:0] CMD_ERS_VFY  = 8'hA0;
  localparam logic [7:0] CMD_PROGRAM  = 8'h40;
  localparam logic [7:0] CMD_PRG_VFY  = 8'hC0;
  localparam logic [7:0] CMD_RESET    = 8'hFF;
endpackage

// File: rtl/cmdreg_strobe.sv
module cmdreg_strobe #(
  parameter int AW = 17,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  input  logic          accept_en,
  output logic          wr_evt,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  logic          we_q;
  logic          armed;
  logic [AW-1:0] fall_addr;
  logic          fall;
  logic          rise;
  logic          complete;

  assign fall     = we_q & ~we_n;
  assign rise     = ~we_q & we_n;
  assign complete = rise & armed & ~ce_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q      <= 1'b1;
      armed     <= 1'b0;
      fall_addr <= '0;
      wr_evt    <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
    end else begin
      we_q   <= we_n;
      wr_evt <= complete & accept_en;
      if (fall) begin
        armed <= ~ce_n;
      end else if (rise) begin
        armed <= 1'b0;
      end
      if (fall && !ce_n) begin
        fall_addr <= addr;
      end
      if (complete) begin
        wr_addr <= fall_addr;
        wr_data <= din;
      end
    end
  end

  // R2
  wr_evt_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt |-> ($past(we_n) && !$past(ce_n)));
endmodule

// File: rtl/cmdreg_fsm.sv
module cmdreg_fsm
  import cmdreg_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hv_ok,
  input  logic          wr_evt,
  input  logic [DW-1:0] wr_data,
  output mode_e         state,
  output logic          prog_start,
  output logic          erase_start,
  output logic          op_stop,
  output logic          ld_prog,
  output logic          ld_vfy
);
  mode_e st_q, st_d;
  logic  ff_q, ff_d;
  logic  ps_d, es_d, stop_d;
  logic  running;
  logic  is_ff;

  assign running = (st_q == M_PROGRAM) || (st_q == M_ERASING);
  assign is_ff   = (wr_data == DW'(CMD_RESET));
  assign state   = st_q;

  always_comb begin
    st_d    = st_q;
    ff_d    = ff_q;
    ps_d    = 1'b0;
    es_d    = 1'b0;
    stop_d  = 1'b0;
    ld_prog = 1'b0;
    ld_vfy  = 1'b0;
    if (!hv_ok) begin
      st_d   = M_READ;
      ff_d   = 1'b0;
      stop_d = running;
    end else if (wr_evt) begin
      ff_d   = is_ff;
      stop_d = running;
      if (is_ff && ff_q) begin
        st_d = M_READ;
      end else begin
        case (st_q)
          M_PRG_SET: begin
            st_d    = M_PROGRAM;
            ps_d    = 1'b1;
            ld_prog = 1'b1;
          end
          M_ERS_SET: begin
            if (wr_data == DW'(CMD_ERASE)) begin
              st_d = M_ERASING;
              es_d = 1'b1;
            end else begin
              st_d = M_READ;
            end
          end
          default: begin
            case (wr_data)
              DW'(CMD_READ):    st_d = M_READ;
              DW'(CMD_ERASE):   st_d = M_ERS_SET;
              DW'(CMD_PROGRAM): st_d = M_PRG_SET;
              DW'(CMD_PRG_VFY): st_d = M_PRG_VFY;
              DW'(CMD_ERS_VFY): begin
                st_d   = M_ERS_VFY;
                ld_vfy = 1'b1;
              end
              default:          st_d = running ? M_READ : st_q;
            endcase
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= M_READ;
      ff_q        <= 1'b0;
      prog_start  <= 1'b0;
      erase_start <= 1'b0;
      op_stop     <= 1'b0;
    end else begin
      st_q        <= st_d;
      ff_q        <= ff_d;
      prog_start  <= ps_d;
      erase_start <= es_d;
      op_stop     <= stop_d;
    end
  end

  // R7
  prog_start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> (st_q == M_PROGRAM));
  // R9
  prog_start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |=> !prog_start);
  // R4
  erase_from_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |-> ($past(st_q) == M_ERS_SET));
  // R8
  stop_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_stop |-> (($past(st_q) == M_PROGRAM) || ($past(st_q) == M_ERASING)));
  // R11
  supply_low_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hv_ok |=> (st_q == M_READ));
endmodule

// File: rtl/cmdreg_oplatch.sv
module cmdreg_oplatch #(
  parameter int AW = 17,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_prog,
  input  logic          ld_vfy,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic [AW-1:0] op_addr,
  output logic [DW-1:0] prog_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_addr   <= '0;
      prog_data <= '1;
    end else begin
      if (ld_prog || ld_vfy) begin
        op_addr <= wr_addr;
      end
      if (ld_prog) begin
        prog_data <= wr_data;
      end
    end
  end

  // R8
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(ld_prog) && !$past(ld_vfy)) |-> $stable(op_addr));
endmodule

// File: rtl/cmdreg_ctrl.sv
module cmdreg_ctrl
  import cmdreg_pkg::*;
#(
  parameter int AW = 17,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  input  logic          hv_ok,
  input  logic          lockout,
  output logic [2:0]    mode,
  output logic          verify_sel,
  output logic          prog_start,
  output logic          erase_start,
  output logic          op_stop,
  output logic          prog_busy,
  output logic          erase_busy,
  output logic [AW-1:0] op_addr,
  output logic [DW-1:0] prog_data
);
  logic [1:0]    rst_pipe;
  logic          rst_s_n;
  logic          wr_evt;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic          ld_prog;
  logic          ld_vfy;
  mode_e         state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_s_n = rst_pipe[1];

  cmdreg_strobe #(.AW(AW), .DW(DW)) u_strobe (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .ce_n      (ce_n),
    .we_n      (we_n),
    .addr      (addr),
    .din       (din),
    .accept_en (hv_ok & ~lockout),
    .wr_evt    (wr_evt),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data)
  );

  cmdreg_fsm #(.DW(DW)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_s_n),
    .hv_ok       (hv_ok),
    .wr_evt      (wr_evt),
    .wr_data     (wr_data),
    .state       (state),
    .prog_start  (prog_start),
    .erase_start (erase_start),
    .op_stop     (op_stop),
    .ld_prog     (ld_prog),
    .ld_vfy      (ld_vfy)
  );

  cmdreg_oplatch #(.AW(AW), .DW(DW)) u_oplatch (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .ld_prog   (ld_prog),
    .ld_vfy    (ld_vfy),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .op_addr   (op_addr),
    .prog_data (prog_data)
  );

  assign mode       = state;
  assign verify_sel = (state == M_ERS_VFY) || (state == M_PRG_VFY);
  assign prog_busy  = (state == M_PROGRAM);
  assign erase_busy = (state == M_ERASING);

  // R12
  lockout_hold_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    ($past(lockout, 2) && $past(lockout) && $past(hv_ok)) |-> $stable(mode));
  // R6
  verify_from_write_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(verify_sel) |-> $past(wr_evt));
endmodule

// File: tb/tb_cmdreg_ctrl.sv
module tb_cmdreg_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 17;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_n = 1'b1;
  logic          we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic          hv_ok = 1'b1;
  logic          lockout = 1'b0;
  logic [2:0]    mode;
  logic          verify_sel, prog_start, erase_start, op_stop, prog_busy, erase_busy;
  logic [AW-1:0] op_addr;
  logic [DW-1:0] prog_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct { int kind; int a; int d; } ev_t;
  ev_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cmdreg_ctrl #(.AW(AW), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .addr(addr), .din(din),
    .hv_ok(hv_ok), .lockout(lockout), .mode(mode), .verify_sel(verify_sel),
    .prog_start(prog_start), .erase_start(erase_start), .op_stop(op_stop),
    .prog_busy(prog_busy), .erase_busy(erase_busy), .op_addr(op_addr),
    .prog_data(prog_data)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic expect_ev(input int kind, input int a, input int d);
    ev_t e;
    e.kind = kind; e.a = a; e.d = d;
    exp_q.push_back(e);
  endtask

  task automatic pop_cmp(input int kind, input string req);
    ev_t e;
    if (exp_q.size() == 0) begin
      check(req, kind, -1);
    end else begin
      e = exp_q.pop_front();
      check(req, kind, e.kind);
      if (kind == 0) begin
        check("R7", int'(op_addr), e.a);
        check("R7", int'(prog_data), e.d);
      end
    end
  endtask

  // monitor: pulses are compared against the scoreboard queue
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (op_stop)     pop_cmp(2, "R8");
      if (prog_start)  pop_cmp(0, "R7");
      if (erase_start) pop_cmp(1, "R4");
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk); addr = AW'(a); ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk); din = DW'(d); we_n = 1'b1;
    @(negedge clk); ce_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1", int'(mode), 0);
    check("R1", int'(verify_sel), 0);
    check("R1", int'(prog_busy | erase_busy | prog_start | erase_start | op_stop), 0);

    // R7 program sequence
    wr(0, 8'h40);
    check("R7", int'(mode), 4);
    expect_ev(0, 'h1234, 'h5A);
    wr('h1234, 8'h5A);
    check("R7", int'(mode), 5);
    check("R7", int'(prog_busy), 1);

    // R8 verify ends program and keeps the address
    expect_ev(2, 0, 0);
    wr('h777, 8'hC0);
    check("R8", int'(mode), 6);
    check("R8", int'(op_addr), 'h1234);
    check("R8", int'(verify_sel), 1);

    // R3 read command
    wr(0, 8'h00);
    check("R3", int'(mode), 0);
    check("R3", int'(verify_sel), 0);

    // R4 erase
    wr(0, 8'h20);
    check("R4", int'(mode), 1);
    expect_ev(1, 0, 0);
    wr(0, 8'h20);
    check("R4", int'(mode), 2);
    check("R4", int'(erase_busy), 1);

    // R6 erase verify ends erase
    expect_ev(2, 0, 0);
    wr('h0ABC, 8'hA0);
    check("R6", int'(mode), 3);
    check("R6", int'(op_addr), 'h0ABC);
    check("R6", int'(verify_sel), 1);

    // R5 erase setup cancelled
    wr(0, 8'h20);
    wr(0, 8'h55);
    check("R5", int'(mode), 0);
    check("R5", int'(erase_busy), 0);

    // R9 null program data then abort
    wr(0, 8'h40);
    expect_ev(0, 'h42, 'hFF);
    wr('h42, 8'hFF);
    check("R9", int'(mode), 5);
    check("R9", int'(prog_data), 'hFF);
    expect_ev(2, 0, 0);
    wr(0, 8'hFF);
    check("R9", int'(mode), 0);

    // R10 lone FFh in verify keeps mode, second returns to read
    wr('h10, 8'hA0);
    wr(0, 8'hFF);
    check("R10", int'(mode), 3);
    wr(0, 8'hFF);
    check("R10", int'(mode), 0);

    // R2 chip-enable high write ignored
    @(negedge clk); addr = '0; ce_n = 1'b1; we_n = 1'b0;
    @(negedge clk); din = 8'h40; we_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R2", int'(mode), 0);
    // R2 address at fall, data at rise
    wr(0, 8'h40);
    expect_ev(0, 'h300, 'h12);
    @(negedge clk); addr = 'h300; din = 8'hEE; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk); addr = 'h3FF;
    @(negedge clk); din = 8'h12; we_n = 1'b1;
    @(negedge clk); ce_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R2", int'(mode), 5);
    expect_ev(2, 0, 0);
    wr(0, 8'hC0);
    wr(0, 8'h00);

    // R11 supply low: writes ignored, running erase stopped
    hv_ok = 1'b0;
    wr(0, 8'h40);
    check("R11", int'(mode), 0);
    hv_ok = 1'b1;
    wr(0, 8'h20);
    expect_ev(1, 0, 0);
    wr(0, 8'h20);
    check("R11", int'(mode), 2);
    expect_ev(2, 0, 0);
    @(negedge clk); hv_ok = 1'b0;
    repeat (2) @(negedge clk);
    check("R11", int'(mode), 0);
    hv_ok = 1'b1;

    // R12 lockout
    lockout = 1'b1;
    wr(0, 8'h40);
    check("R12", int'(mode), 0);
    lockout = 1'b0;
    wr(0, 8'h40);
    check("R12", int'(mode), 4);
    expect_ev(0, 'h5, 'hFF);
    wr('h5, 8'hFF);
    expect_ev(2, 0, 0);
    wr(0, 8'hFF);
    check("R10", int'(mode), 0);

    repeat (4) @(negedge clk);
    // R4 every expected pulse was observed
    check("R4", exp_q.size(), 0);
    finish_run();
  end
endmodule